// File: doc/BRIEF.md
# Multi-Register Transfer Address Sequencer

This block runs a block transfer between a set of registers and word-addressed memory. A caller presents a register-select mask, a base address, a direction for the data (read or write), one of four addressing modes, and a writeback enable, and then pulses start. The sequencer works out the span of addresses that the transfer covers. It then issues one word access per selected register over a request/ready memory port. Each access carries the register index and its address.

Registers always map in ascending index order onto ascending addresses, whatever the addressing mode. The mode only decides where the span sits relative to the base. On reads, each returned word comes back one cycle later, tagged with its register index, so that a register file outside the block can capture it. When the last access has completed, the block pulses done and presents the updated base: the base moved by four bytes per selected register when writeback is on, or the original base when it is off.

Top module: `mreg_xfer_seq`

## Requirements
- R1: With mode_i = 2'b00 (increment, step after), the first access address is the base and the last is base + 4N − 4, where N is the number of set bits in reg_list_i.
- R2: With mode_i = 2'b01 (increment, step before), the first access address is base + 4 and the last is base + 4N.
- R3: With mode_i = 2'b10 (decrement, step after), the first access address is base − 4N + 4 and the last is the base.
- R4: With mode_i = 2'b11 (decrement, step before), the first access address is base − 4N and the last is base − 4.
- R5: Accesses go in ascending register index (reg_list_i bit i selects register i), and each access address is 4 above the previous one.
- R6: At done, new_base_o equals base + 4N for the increment modes and base − 4N for the decrement modes when wb_en_i was 1, and equals the base when wb_en_i was 0. Addresses wrap modulo 2^ADDR_W.
- R7: While req_o is high and ready_i is low, req_o, addr_o, reg_idx_o and we_o hold their values into the next cycle.
- R8: load_i = 1 selects reads (we_o = 0) and load_i = 0 selects writes (we_o = 1). For each completed read, ld_valid_o is high in the following cycle, with ld_idx_o set to the register index and ld_data_o set to the rdata_i value sampled at the handshake. ld_valid_o stays low for writes.
- R9: Exactly N accesses are made, and done_o is high for exactly one cycle, namely the cycle after the last handshake.
- R10: An empty reg_list_i makes no access, and done_o is high in the cycle after start, with new_base_o equal to the base.
- R11: While busy_o is high, start_i and all the request inputs are ignored. The transfer uses the values captured at start, and busy_o is low in the cycle after done.
- R12: After reset, busy_o, req_o, done_o and ld_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (accepted when idle) |
| reg_list_i | input | REG_CNT | Register-select mask |
| base_i | input | ADDR_W | Base address |
| load_i | input | 1 | 1 = read memory into registers, 0 = write |
| mode_i | input | 2 | Addressing mode: bit 1 = decrement, bit 0 = step before |
| wb_en_i | input | 1 | Report an updated base |
| busy_o | output | 1 | Transfer in progress |
| req_o | output | 1 | Memory access request |
| we_o | output | 1 | Access is a write |
| addr_o | output | ADDR_W | Access address |
| reg_idx_o | output | $clog2(REG_CNT) | Register index of the current access |
| ready_i | input | 1 | Memory accepts the access this cycle |
| rdata_i | input | DATA_W | Read data, valid with ready_i on reads |
| ld_valid_o | output | 1 | Read word returned |
| ld_idx_o | output | $clog2(REG_CNT) | Register index of the returned word |
| ld_data_o | output | DATA_W | Returned word |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| new_base_o | output | ADDR_W | Base value reported at done |

## Verification
The bench builds the block with REG_CNT = 4 and ADDR_W = 20. This small mask width allows a full sweep: every one of the 16 masks is run in all four modes, in both directions and with writeback both on and off. Bases sit near the top and the bottom of the 20-bit space, so that wraparound of the span and of the written-back base is exercised, along with the 0x8_0010 read of registers 1 to 3. The memory's ready line follows an irregular stall pattern, so that the hold behaviour and the read-return timing are both exercised, and new request inputs are presented during each transfer to show that they are ignored.

// File: rtl/mreg_xfer_pkg.sv
package mreg_xfer_pkg;
  typedef enum logic [1:0] {
    AM_INC_POST = 2'b00,
    AM_INC_PRE  = 2'b01,
    AM_DEC_POST = 2'b10,
    AM_DEC_PRE  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mreg_popcount.sv
module mreg_popcount #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/mreg_lowbit.sv
module mreg_lowbit #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) if (vec_i[i]) idx_o = IW'(i);
  end
endmodule

// File: rtl/mreg_addr_plan.sv
module mreg_addr_plan
  import mreg_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  addr_mode_e        mode_i,
  output logic [ADDR_W-1:0] low_o,
  output logic [ADDR_W-1:0] wb_o
);
  localparam int SHIFT = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0] span;
  logic              dec, pre;

  always_comb begin
    span  = ADDR_W'(cnt_i) << SHIFT;
    dec   = mode_i[1];
    pre   = mode_i[0];
    // lowest word of the span, then one-word nudge for post-dec / pre-inc
    low_o = (dec ? base_i - span : base_i)
          + ((pre ^ dec) ? ADDR_W'(WORD_BYTES) : '0);
    wb_o  = dec ? base_i - span : base_i + span;
  end
endmodule

// File: rtl/mreg_xfer_seq.sv
module mreg_xfer_seq
  import mreg_xfer_pkg::*;
#(
  parameter int REG_CNT    = 16,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(REG_CNT),
  localparam int CNT_W     = $clog2(REG_CNT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [REG_CNT-1:0] reg_list_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic               load_i,
  input  logic [1:0]         mode_i,
  input  logic               wb_en_i,
  output logic               busy_o,
  output logic               req_o,
  output logic               we_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [IDX_W-1:0]   reg_idx_o,
  input  logic               ready_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic               ld_valid_o,
  output logic [IDX_W-1:0]   ld_idx_o,
  output logic [DATA_W-1:0]  ld_data_o,
  output logic               done_o,
  output logic [ADDR_W-1:0]  new_base_o
);
  seq_state_e         state_q;
  logic [REG_CNT-1:0] mask_q, mask_nxt;
  logic [ADDR_W-1:0]  addr_q, nbase_q, low_addr, wb_addr;
  logic               load_q, ld_valid_q;
  logic [IDX_W-1:0]   cur_idx, ld_idx_q;
  logic [DATA_W-1:0]  ld_data_q;
  logic [CNT_W-1:0]   sel_cnt;
  logic               hs;

  mreg_popcount #(.W(REG_CNT), .CW(CNT_W)) u_cnt (
    .vec_i(reg_list_i), .cnt_o(sel_cnt)
  );

  mreg_addr_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_plan (
    .base_i(base_i), .cnt_i(sel_cnt), .mode_i(addr_mode_e'(mode_i)),
    .low_o(low_addr), .wb_o(wb_addr)
  );

  mreg_lowbit #(.W(REG_CNT), .IW(IDX_W)) u_low (
    .vec_i(mask_q), .idx_o(cur_idx)
  );

  assign hs       = (state_q == ST_RUN) && ready_i;
  assign mask_nxt = mask_q & (mask_q - 1'b1);  // retire lowest pending register

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      nbase_q <= '0;
      load_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          load_q  <= load_i;
          mask_q  <= reg_list_i;
          addr_q  <= low_addr;
          nbase_q <= wb_en_i ? wb_addr : base_i;
          state_q <= (|reg_list_i) ? ST_RUN : ST_FIN;
        end
        ST_RUN: if (ready_i) begin
          mask_q <= mask_nxt;
          addr_q <= addr_q + ADDR_W'(WORD_BYTES);
          if (!(|mask_nxt)) state_q <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_q <= 1'b0;
      ld_idx_q   <= '0;
      ld_data_q  <= '0;
    end else begin
      ld_valid_q <= hs && load_q;
      if (hs && load_q) begin
        ld_idx_q  <= cur_idx;
        ld_data_q <= rdata_i;
      end
    end
  end

  assign busy_o     = state_q != ST_IDLE;
  assign req_o      = state_q == ST_RUN;
  assign we_o       = req_o && !load_q;
  assign addr_o     = addr_q;
  assign reg_idx_o  = cur_idx;
  assign ld_valid_o = ld_valid_q;
  assign ld_idx_o   = ld_idx_q;
  assign ld_data_o  = ld_data_q;
  assign done_o     = state_q == ST_FIN;
  assign new_base_o = nbase_q;
endmodule

// File: rtl/mreg_xfer_seq_chk.sv
module mreg_xfer_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int WORD_BYTES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_o,
  input logic              we_o,
  input logic              ready_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [IDX_W-1:0]  reg_idx_o,
  input logic              ld_valid_o,
  input logic              done_o
);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ready_i |=> req_o && $stable(addr_o) && $stable(reg_idx_o) && $stable(we_o));

  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ready_i |=> !req_o || addr_o == $past(addr_o) + ADDR_W'(WORD_BYTES));

  a_r5_idx_rising: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ready_i |=> !req_o || reg_idx_o > $past(reg_idx_o));

  a_r8_ld_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> $past(req_o && ready_i && !we_o));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o && !$past(req_o && !ready_i));
endmodule

bind mreg_xfer_seq mreg_xfer_seq_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_o(req_o), .we_o(we_o), .ready_i(ready_i),
  .addr_o(addr_o), .reg_idx_o(reg_idx_o), .ld_valid_o(ld_valid_o), .done_o(done_o)
);

// File: tb/mreg_xfer_seq_test.sv
module mreg_xfer_seq_test;
  localparam int RC = 4;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam int IW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [RC-1:0] reg_list_i = '0;
  logic [AW-1:0] base_i = '0;
  logic          load_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic          wb_en_i = 1'b0;
  logic          busy_o, req_o, we_o, ready_i, ld_valid_o, done_o;
  logic [AW-1:0] addr_o, new_base_o;
  logic [IW-1:0] reg_idx_o, ld_idx_o;
  logic [DW-1:0] rdata_i, ld_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  int stall_seq = 0;
  logic [AW-1:0] got_addr [4];

  always #2 clk_i = ~clk_i;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a[11:0], a} ^ 32'hC3A5_0F96;
  endfunction

  assign rdata_i = mem_word(addr_o);

  initial ready_i = 1'b0;

  mreg_xfer_seq #(.REG_CNT(RC), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .reg_list_i(reg_list_i),
    .base_i(base_i), .load_i(load_i), .mode_i(mode_i), .wb_en_i(wb_en_i),
    .busy_o(busy_o), .req_o(req_o), .we_o(we_o), .addr_o(addr_o),
    .reg_idx_o(reg_idx_o), .ready_i(ready_i), .rdata_i(rdata_i),
    .ld_valid_o(ld_valid_o), .ld_idx_o(ld_idx_o), .ld_data_o(ld_data_o),
    .done_o(done_o), .new_base_o(new_base_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nth_set(input logic [RC-1:0] m, input int k);
    int seen = 0;
    for (int i = 0; i < RC; i++) if (m[i]) begin
      if (seen == k) return i;
      seen++;
    end
    return -1;
  endfunction

  task automatic run_xfer(input logic [RC-1:0] list, input logic [AW-1:0] base,
                          input bit ld, input logic [1:0] mode, input bit wb);
    int n = $countones(list);
    logic [AW-1:0] span = AW'(4 * n);
    logic [AW-1:0] low, exp_base, prev_addr;
    string mtag;
    int hs = 0;
    bit pend = 0, done_seen = 0, last_prev = 0, prev_stall = 0;
    int pend_idx = 0;
    logic [AW-1:0] pend_addr = '0;
    prev_addr = '0;
    case (mode)
      2'b00: begin low = base;            mtag = "R1"; end
      2'b01: begin low = base + 20'd4;    mtag = "R2"; end
      2'b10: begin low = base - span + 20'd4; mtag = "R3"; end
      default: begin low = base - span;   mtag = "R4"; end
    endcase
    exp_base = !wb ? base : (mode[1] ? base - span : base + span);

    @(negedge clk_i);
    reg_list_i = list; base_i = base; load_i = ld; mode_i = mode; wb_en_i = wb; start_i = 1'b1;
    @(negedge clk_i);
    // new request while busy: must be ignored (R11)
    reg_list_i = ~list; base_i = ~base; load_i = !ld; mode_i = ~mode; wb_en_i = !wb;
    for (int cyc = 0; cyc < 80 && !done_seen; cyc++) begin
      if (cyc > 0) @(negedge clk_i);
      if (cyc == 1) start_i = 1'b0;
      if (pend) begin
        chk(ld_valid_o === 1'b1, "R8 ld_valid", 32'(ld_valid_o), 1);
        chk(ld_idx_o == IW'(pend_idx), "R8 ld_idx", 32'(ld_idx_o), 32'(pend_idx));
        chk(ld_data_o == mem_word(pend_addr), "R8 ld_data", ld_data_o, mem_word(pend_addr));
      end else begin
        chk(ld_valid_o === 1'b0, "R8 no ld_valid", 32'(ld_valid_o), 0);
      end
      pend = 0;
      if (done_o) begin
        chk(hs == n, "R9 access count", 32'(hs), 32'(n));
        if (n == 0) chk(cyc == 0, "R10 empty done timing", 32'(cyc), 0);
        else chk(last_prev, "R9 done after last handshake", 32'(last_prev), 1);
        chk(new_base_o == exp_base, n == 0 ? "R10 base" : "R6 base", 32'(new_base_o), 32'(exp_base));
        chk(req_o === 1'b0, "R9 no req at done", 32'(req_o), 0);
        done_seen = 1;
        last_prev = 0;
      end else if (req_o) begin
        logic [AW-1:0] ea = low + AW'(4 * hs);
        int ei = nth_set(list, hs);
        if (hs == 0) chk(addr_o == low, {mtag, " first addr"}, 32'(addr_o), 32'(low));
        else chk(addr_o == ea, "R5 addr step", 32'(addr_o), 32'(ea));
        if (hs == n - 1) begin
          logic [AW-1:0] hi;
          case (mode)
            2'b00: hi = base + span - 20'd4;
            2'b01: hi = base + span;
            2'b10: hi = base;
            default: hi = base - 20'd4;
          endcase
          chk(addr_o == hi, {mtag, " last addr"}, 32'(addr_o), 32'(hi));
        end
        chk(32'(reg_idx_o) == 32'(ei), "R5 reg order", 32'(reg_idx_o), 32'(ei));
        chk(we_o === !ld, "R8 write enable", 32'(we_o), 32'(!ld));
        if (prev_stall) chk(addr_o == prev_addr, "R7 hold", 32'(addr_o), 32'(prev_addr));
        if (hs < 4) got_addr[hs] = addr_o;
        stall_seq++;
        ready_i = ((stall_seq * 7) % 5) != 0;
        prev_addr = addr_o;
        prev_stall = !ready_i;
        if (ready_i) begin
          if (ld) begin pend = 1; pend_idx = ei; pend_addr = addr_o; end
          hs++;
          last_prev = (hs == n);
        end else last_prev = 0;
      end else begin
        chk(0, "R9 unexpected idle during transfer", 32'(req_o), 1);
        done_seen = 1;
      end
    end
    if (!done_seen) chk(0, "R9 transfer watchdog", 0, 1);
    @(negedge clk_i);
    start_i = 1'b0; ready_i = 1'b0;
    chk(busy_o === 1'b0, "R11 idle after done", 32'(busy_o), 0);
    chk(req_o === 1'b0, "R11 no stray start", 32'(req_o), 0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] bases [3];
    bases[0] = 20'h8_0010; bases[1] = 20'h0_0004; bases[2] = 20'hF_FFF4;
    #1;
    chk(busy_o === 1'b0 && req_o === 1'b0, "R12 reset busy/req", {busy_o, req_o}, 0);
    chk(done_o === 1'b0 && ld_valid_o === 1'b0, "R12 reset done/ld", {done_o, ld_valid_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(busy_o === 1'b0, "R12 idle after release", 32'(busy_o), 0);

    // read of registers 1..3, increment after, base 0x8_0010 (R1, R6)
    run_xfer(4'b1110, 20'h8_0010, 1'b1, 2'b00, 1'b1);
    chk(got_addr[0] == 20'h8_0010, "R1 example addr0", 32'(got_addr[0]), 32'h8_0010);
    chk(got_addr[1] == 20'h8_0014, "R1 example addr1", 32'(got_addr[1]), 32'h8_0014);
    chk(got_addr[2] == 20'h8_0018, "R1 example addr2", 32'(got_addr[2]), 32'h8_0018);
    chk(new_base_o == 20'h8_001C, "R6 example base", 32'(new_base_o), 32'h8_001C);

    for (int b = 0; b < 3; b++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 16; l++)
          for (int d = 0; d < 2; d++)
            for (int w = 0; w < 2; w++)
              run_xfer(RC'(l), bases[b], d[0], 2'(m), w[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule